// File: doc/BRIEF.md
# Timer Interrupt Reinjection Tracker

This block sits between a periodic timer and an interrupt controller. It keeps a backlog of timer expiries that software has not yet acknowledged, so that expiries which occur while an earlier interrupt is still being serviced are not lost. Instead, they are replayed one at a time.

An internal arm flag records whether the last interrupt has been acknowledged. Whenever the backlog is nonzero and the block is armed, it emits a one-cycle interrupt pulse and disarms. Each acknowledge removes one expiry from the backlog and re-arms the block. If expiries are still waiting, the next pulse follows at once.

Masking the interrupt line discards the backlog and re-arms the block. Reprogramming the timer discards only the backlog.

Top module: `tmr_reinject_tracker`

## Requirements
- R1: After synchronous reset the backlog is zero, `pending_nz_o` and `irq_pulse_o` are low, and the block is armed, so the first tick leads to a pulse without a prior acknowledge.
- R2: A tick alone adds one to the backlog; `pending_nz_o` reflects the new backlog in the cycle after the tick.
- R3: The backlog is `CNT_W` bits wide (8 by default) and stops at its maximum (255); further ticks are dropped, so exactly 255 pulses are replayed from a full backlog.
- R4: An acknowledge alone removes one from the backlog and never takes it below zero; an acknowledge at zero leaves `pending_nz_o` low.
- R5: A tick and an acknowledge in the same cycle leave the backlog unchanged.
- R6: `irq_pulse_o` rises one cycle after a cycle in which the backlog was nonzero and the block was armed, and it is high for exactly one cycle.
- R7: Issuing a pulse disarms the block; while disarmed, no further pulse is produced whatever the backlog, until an acknowledge arrives.
- R8: An acknowledge re-arms the block, so a backlog of N yields N pulses for N acknowledges, one per acknowledge.
- R9: `mask_i` clears the backlog, re-arms the block and suppresses the pulse in the next cycle.
- R10: `reprog_i` clears the backlog but leaves the arm flag as it was.
- R11: Priority is reset, then mask, then reprogram, then tick/acknowledge; a tick in the same cycle as a clear is discarded.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick_i | input | 1 | One-cycle timer expiry strobe |
| ack_i | input | 1 | One-cycle interrupt acknowledge strobe |
| mask_i | input | 1 | Interrupt line masked; clears backlog and re-arms |
| reprog_i | input | 1 | Timer reprogrammed; clears backlog |
| irq_pulse_o | output | 1 | Registered one-cycle interrupt pulse |
| pending_nz_o | output | 1 | Registered flag: backlog is nonzero |

## Verification
The assertions assume that `ack_i` answers an interrupt that has already been issued. They also assume that the strobes are synchronous and last one cycle each. The saturation and floor properties also rely on `mask_i` and `reprog_i` being the only clears.

The vector table and the replay loop follow this protocol: every acknowledge is placed after a pulse. There is one deliberate exception, a lone acknowledge at an empty backlog, and it is chosen so that it disturbs neither the arm flag nor the count. Concurrent tick/acknowledge and tick/clear cases are driven explicitly, so the priority and hold rules are exercised inside these assumptions.

// File: rtl/tmr_reinj_pkg.sv
package tmr_reinj_pkg;
  // Operation applied to the backlog counter in a cycle
  typedef enum logic [1:0] {
    BL_HOLD = 2'd0,
    BL_INC  = 2'd1,
    BL_DEC  = 2'd2,
    BL_CLR  = 2'd3
  } bl_op_e;
endpackage

// File: rtl/tmr_backlog_ctr.sv
module tmr_backlog_ctr
  import tmr_reinj_pkg::*;
#(
  parameter int unsigned CNT_W = 8
) (
  input  logic clk,
  input  logic rst,
  input  logic clr_i,
  input  logic tick_i,
  input  logic ack_i,
  output logic nz_o
);
  localparam logic [CNT_W-1:0] CNT_MAX  = {CNT_W{1'b1}};
  localparam logic [CNT_W-1:0] CNT_ZERO = '0;
  localparam logic [CNT_W-1:0] CNT_ONE  = {{(CNT_W-1){1'b0}}, 1'b1};

  logic [CNT_W-1:0] cnt_q, cnt_d;
  bl_op_e           op;

  // Decode the cycle's operation; clear dominates, tick+ack cancel
  always_comb begin
    op = BL_HOLD;
    if (clr_i)
      op = BL_CLR;
    else if (tick_i && !ack_i && (cnt_q != CNT_MAX))
      op = BL_INC;
    else if (ack_i && !tick_i && (cnt_q != CNT_ZERO))
      op = BL_DEC;
  end

  always_comb begin
    unique case (op)
      BL_INC:  cnt_d = cnt_q + CNT_ONE;
      BL_DEC:  cnt_d = cnt_q - CNT_ONE;
      BL_CLR:  cnt_d = CNT_ZERO;
      default: cnt_d = cnt_q;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= CNT_ZERO;
      nz_o  <= 1'b0;
    end else begin
      cnt_q <= cnt_d;
      nz_o  <= (cnt_d != CNT_ZERO);
    end
  end

  // R3: a full backlog does not wrap on a further tick
  p_no_overflow_r3: assert property (@(posedge clk) disable iff (rst)
    (cnt_q == CNT_MAX && tick_i && !ack_i && !clr_i) |=> (cnt_q == CNT_MAX));

  // R4: an acknowledge at zero does not wrap below zero
  p_floor_r4: assert property (@(posedge clk) disable iff (rst)
    (cnt_q == CNT_ZERO && ack_i && !tick_i && !clr_i) |=> (cnt_q == CNT_ZERO && !nz_o));

  // R5: simultaneous tick and acknowledge hold the count
  p_cancel_r5: assert property (@(posedge clk) disable iff (rst)
    (tick_i && ack_i && !clr_i) |=> $stable(cnt_q));

  // R9/R10: a clear empties the backlog
  p_clear_r10: assert property (@(posedge clk) disable iff (rst)
    clr_i |=> (!nz_o && cnt_q == CNT_ZERO));
endmodule

// File: rtl/tmr_issue_gate.sv
module tmr_issue_gate (
  input  logic clk,
  input  logic rst,
  input  logic rearm_i,
  input  logic ack_i,
  input  logic backlog_nz_i,
  output logic irq_o
);
  logic armed_q;
  logic issue;

  assign issue = backlog_nz_i && armed_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      armed_q <= 1'b1;
      irq_o   <= 1'b0;
    end else if (rearm_i) begin
      armed_q <= 1'b1;
      irq_o   <= 1'b0;
    end else begin
      irq_o <= issue;
      if (issue)
        armed_q <= 1'b0;
      else if (ack_i)
        armed_q <= 1'b1;
    end
  end

  // R6: the pulse lasts one cycle
  p_one_cycle_r6: assert property (@(posedge clk) disable iff (rst)
    irq_o |=> !irq_o);

  // R6: a pulse needs a nonzero backlog in the cycle before
  p_needs_backlog_r6: assert property (@(posedge clk) disable iff (rst)
    $rose(irq_o) |-> $past(backlog_nz_i));

  // R7: while disarmed and without acknowledge, nothing is issued
  p_blocked_r7: assert property (@(posedge clk) disable iff (rst)
    (!armed_q && !ack_i && !rearm_i) |=> !irq_o);

  // R9: masking re-arms and suppresses the pulse
  p_rearm_r9: assert property (@(posedge clk) disable iff (rst)
    rearm_i |=> (armed_q && !irq_o));
endmodule

// File: rtl/tmr_reinject_tracker.sv
module tmr_reinject_tracker #(
  parameter int unsigned CNT_W = 8
) (
  input  logic clk,
  input  logic rst,
  input  logic tick_i,
  input  logic ack_i,
  input  logic mask_i,
  input  logic reprog_i,
  output logic irq_pulse_o,
  output logic pending_nz_o
);
  logic backlog_clr;

  // Mask and reprogram both drop the backlog; only mask re-arms
  assign backlog_clr = mask_i || reprog_i;

  tmr_backlog_ctr #(.CNT_W(CNT_W)) u_backlog (
    .clk    (clk),
    .rst    (rst),
    .clr_i  (backlog_clr),
    .tick_i (tick_i),
    .ack_i  (ack_i),
    .nz_o   (pending_nz_o)
  );

  tmr_issue_gate u_gate (
    .clk          (clk),
    .rst          (rst),
    .rearm_i      (mask_i),
    .ack_i        (ack_i),
    .backlog_nz_i (pending_nz_o),
    .irq_o        (irq_pulse_o)
  );

  // R1: nothing is pending or issued right after reset
  p_reset_idle_r1: assert property (@(posedge clk)
    $fell(rst) |-> (!pending_nz_o && !irq_pulse_o));
endmodule

// File: tb/tmr_reinject_tracker_tb.sv
module tmr_reinject_tracker_tb;
  localparam int CLK_P = 10;
  localparam int NVEC  = 27;
  // {tick, ack, mask, reprog, exp_irq, exp_nz}
  localparam logic [5:0] VEC [NVEC] = '{
    6'b000000, 6'b100001, 6'b000011, 6'b100001, 6'b100001, 6'b010001,
    6'b000011, 6'b110001, 6'b000011, 6'b010001, 6'b000011, 6'b010000,
    6'b000000, 6'b010000, 6'b100001, 6'b100011, 6'b001000, 6'b000000,
    6'b100001, 6'b000011, 6'b000100, 6'b100001, 6'b000001, 6'b010000,
    6'b000000, 6'b101000, 6'b000000
  };

  logic clk = 1'b0;
  logic rst, tick_i, ack_i, mask_i, reprog_i;
  logic irq_pulse_o, pending_nz_o;
  int total = 0;
  int bad = 0;
  int pulses;

  always #(CLK_P/2) clk = ~clk;

  tmr_reinject_tracker u_dut (
    .clk(clk), .rst(rst), .tick_i(tick_i), .ack_i(ack_i),
    .mask_i(mask_i), .reprog_i(reprog_i),
    .irq_pulse_o(irq_pulse_o), .pending_nz_o(pending_nz_o)
  );

  function automatic string tag_of(input int i);
    case (i)
      1, 3, 4, 14, 18, 21: return "R2";
      2, 6, 8, 10, 19:     return "R6";
      5, 9:                return "R8";
      7:                   return "R5";
      11, 12, 13:          return "R4";
      15, 22:              return "R7";
      16, 17:              return "R9";
      20, 23, 24:          return "R10";
      25, 26:              return "R11";
      default:             return "R1";
    endcase
  endfunction

  task automatic check(input string req, input string what, input logic act, input logic exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s: actual=%b expected=%b", req, what, act, exp);
    end
  endtask

  // Drive at a falling edge, let one rising edge pass, return at the next falling edge
  task automatic cyc(input logic t, input logic a, input logic m, input logic p);
    tick_i = t; ack_i = a; mask_i = m; reprog_i = p;
    @(negedge clk);
  endtask

  task automatic do_reset();
    rst = 1'b1;
    cyc(0, 0, 0, 0);
    cyc(0, 0, 0, 0);
    rst = 1'b0;
  endtask

  initial begin
    #(CLK_P * 100000);
    bad++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    rst = 1'b1; tick_i = 0; ack_i = 0; mask_i = 0; reprog_i = 0;
    @(negedge clk);
    do_reset();
    check("R1", "irq after reset", irq_pulse_o, 1'b0);
    check("R1", "nz after reset", pending_nz_o, 1'b0);

    for (int i = 0; i < NVEC; i++) begin
      cyc(VEC[i][5], VEC[i][4], VEC[i][3], VEC[i][2]);
      check(tag_of(i), $sformatf("vec %0d irq", i), irq_pulse_o, VEC[i][1]);
      check(tag_of(i), $sformatf("vec %0d nz", i), pending_nz_o, VEC[i][0]);
    end

    // R3: fill beyond the maximum, then replay the whole backlog
    do_reset();
    pulses = 0;
    for (int i = 0; i < 300; i++) begin
      cyc(1, 0, 0, 0);
      if (irq_pulse_o) pulses++;
    end
    check("R3", "nz when full", pending_nz_o, 1'b1);
    for (int i = 0; i < 260; i++) begin
      cyc(0, 1, 0, 0);
      cyc(0, 0, 0, 0);
      if (irq_pulse_o) pulses++;
    end
    check("R3", "replayed pulses == 255", pulses == 255, 1'b1);
    check("R8", "backlog empty after replay", pending_nz_o, 1'b0);

    // R11: reset overrides a concurrent tick and re-arms (R1)
    cyc(1, 0, 0, 0);
    cyc(0, 0, 0, 0);
    rst = 1'b1;
    cyc(1, 0, 0, 0);
    rst = 1'b0;
    check("R11", "nz after reset with tick", pending_nz_o, 1'b0);
    check("R11", "irq after reset with tick", irq_pulse_o, 1'b0);
    cyc(1, 0, 0, 0);
    cyc(0, 0, 0, 0);
    check("R1", "armed after reset: first pulse", irq_pulse_o, 1'b1);

    // R11: mask beats reprogram and tick together; mask re-arms
    cyc(1, 0, 1, 1);
    check("R11", "mask+reprog+tick nz", pending_nz_o, 1'b0);
    cyc(1, 0, 0, 0);
    cyc(0, 0, 0, 0);
    check("R9", "pulse after mask re-arm", irq_pulse_o, 1'b1);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule